// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programming state of an interrupt router: one 64-bit redirection entry per interrupt pin, plus a small identification register and a fixed version word. Software reaches all of it through only two bus offsets. The first is an index register that software writes with the number of the register it wants. The second is a data window that reads or writes the register that index names. Each 64-bit entry takes two consecutive index values, one for its low 32-bit word and one for its high word.

The block also tells the surrounding fabric whether a bus address falls inside its window. This depends on an enable input, a programmable base and a fixed window length. Every pin's mask bit, which is bit 16 of its entry, is mirrored into a flat output vector so that interrupt logic next to the block can gate pins without decoding the table. An index that names nothing causes a single-cycle error pulse.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, the index register reads 0, the ID is 0, and every entry's low word reads 0x00010000 (mask bit 16 set, all else zero). Every high word reads 0, and `mask_vec` is all ones.
- R2: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the index register (8 bits, read back zero-extended). Offset 0x10 is the data window. Any other offset reads as 0 and ignores writes.
- R3: Index 0x01 is the version word. It reads pin count minus one in bits 23:16 and the 4-bit version code in bits 3:0, with all other bits zero (0x00170001 with default parameters). Writes to it change nothing.
- R4: Index 0x00 is the ID register. A write loads a 4-bit ID from `wdata[27:24]`, and a read returns the ID in bits 27:24 with all other bits zero.
- R5: Index 0x02 is the arbitration register. Reads return the ID in bits 27:24, and writes to it leave the ID unchanged.
- R6: Entry n is reached at index 0x10+2n (bits 31:0) and 0x11+2n (bits 63:32). A write to one half leaves the other half unchanged.
- R7: After any write to entry n, `mask_vec[n]` equals bit 16 of that entry. `mask_vec` changes only after a window write.
- R8: `hit` is high only when `en` is high and `base_addr <= bus_addr <= base_addr + WIN_LEN`, with both ends included.
- R9: An index of 0x03 to 0x0F, or one whose entry number is at or beyond the pin count, is invalid. A window access with it reads 0, a write with it is dropped, and `err` pulses high in the cycle after the access.
- R10: `err` stays low after accesses with a valid index and after cycles with no window access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Window enable for address decode |
| base_addr | input | AW | Window base address |
| bus_addr | input | AW | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from address and state |
| hit | output | 1 | Address inside enabled window |
| err | output | 1 | One-cycle pulse after an invalid window access |
| mask_vec | output | PINS | Per-pin mask mirror |

## Verification
The bench uses the default 24 pins, a 32-bit address and a window length of 0x100. With 24 pins, index 0x3F is the last valid index and 0x40 is the first invalid one, so both sides of the table's upper edge can be reached with 8-bit index writes. The version word then has a known value, 0x00170001. The bench uses a base address with nonzero upper bits to show that offsets ignore those bits, and it probes the inclusive window ends at base and base+0x100, plus one address beyond each end.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int PINS = 24,
  parameter int AW = 32,
  parameter logic [AW-1:0] WIN_LEN = 'h100,
  parameter logic [3:0] VER_CODE = 4'h1,
  parameter logic [7:0] SEL_OFF = 8'h00,
  parameter logic [7:0] WIN_OFF = 8'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   bus_addr,
  input  logic            rd,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            hit,
  output logic            err,
  output logic [PINS-1:0] mask_vec
);
  localparam int IW = $clog2(PINS);
  localparam int MBIT = 16;
  localparam logic [7:0] IX_ID = 8'h00;
  localparam logic [7:0] IX_VER = 8'h01;
  localparam logic [7:0] IX_ARB = 8'h02;
  localparam logic [7:0] IX_TBL = 8'h10;
  localparam logic [6:0] NPINS = 7'(PINS);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 12'h000, VER_CODE};
  localparam logic [63:0] ENT_RST = 64'h1 << MBIT;

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic        err_q;
  logic [63:0] tbl [PINS];
  logic [PINS-1:0] mask_q;

  logic [7:0]    off;
  logic [7:0]    rel;
  logic [6:0]    ent;
  logic [IW-1:0] ent_i;
  logic          ent_ok, fixed_sel, bad_sel, win_acc, win_wr;
  logic [63:0]   cur, nxt;
  logic [31:0]   win_rd;
  logic [AW:0]   top_addr;

  assign off = bus_addr[7:0];
  assign rel = sel_q - IX_TBL;
  assign ent = rel[7:1];
  assign ent_i = ent[IW-1:0];
  assign ent_ok = (sel_q >= IX_TBL) && (ent < NPINS);
  assign fixed_sel = (sel_q == IX_ID) || (sel_q == IX_VER) || (sel_q == IX_ARB);
  assign bad_sel = !fixed_sel && !ent_ok;
  assign win_acc = (rd || wr) && (off == WIN_OFF);
  assign win_wr = wr && (off == WIN_OFF);
  assign cur = tbl[ent_i];
  assign nxt = sel_q[0] ? {wdata, cur[31:0]} : {cur[63:32], wdata};

  always_comb begin
    case (sel_q)
      IX_ID, IX_ARB: win_rd = {4'h0, id_q, 24'h000000};
      IX_VER:        win_rd = VER_WORD;
      default:       win_rd = !ent_ok ? 32'h0 : (sel_q[0] ? cur[63:32] : cur[31:0]);
    endcase
  end

  assign rdata = (off == SEL_OFF) ? {24'h0, sel_q} :
                 (off == WIN_OFF) ? win_rd : 32'h0;

  assign top_addr = {1'b0, base_addr} + {1'b0, WIN_LEN};
  assign hit = en && (bus_addr >= base_addr) && ({1'b0, bus_addr} <= top_addr);
  assign err = err_q;
  assign mask_vec = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      err_q  <= 1'b0;
      mask_q <= '1;
      for (int i = 0; i < PINS; i++) tbl[i] <= ENT_RST;
    end else begin
      err_q <= win_acc && bad_sel;
      if (wr && off == SEL_OFF) sel_q <= wdata[7:0];
      if (win_wr) begin
        if (sel_q == IX_ID) begin
          id_q <= wdata[27:24];
        end else if (ent_ok) begin
          tbl[ent_i]    <= nxt;
          mask_q[ent_i] <= nxt[MBIT];
        end
      end
    end
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int PINS = 24,
  parameter int AW = 32,
  parameter logic [3:0] VER_CODE = 4'h1,
  parameter logic [7:0] SEL_OFF = 8'h00,
  parameter logic [7:0] WIN_OFF = 8'h10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [AW-1:0]   bus_addr,
  input logic            rd,
  input logic            wr,
  input logic [31:0]     rdata,
  input logic            hit,
  input logic            err,
  input logic [PINS-1:0] mask_vec,
  input logic [7:0]      sel
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 12'h000, VER_CODE};

  p_other_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:0] != SEL_OFF && bus_addr[7:0] != WIN_OFF) |-> rdata == 32'h0);

  p_version_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:0] == WIN_OFF && sel == 8'h01) |-> rdata == VER_WORD);

  p_id_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:0] == WIN_OFF && (sel == 8'h00 || sel == 8'h02))
      |-> (rdata[23:0] == 24'h0 && rdata[31:28] == 4'h0));

  p_mask_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_vec) |-> $past(wr && bus_addr[7:0] == WIN_OFF));

  p_hit_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en);

  p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past((rd || wr) && bus_addr[7:0] == WIN_OFF));
endmodule

bind irq_route_regs irq_route_regs_chk #(
  .PINS(PINS), .AW(AW), .VER_CODE(VER_CODE), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_addr(bus_addr), .rd(rd), .wr(wr),
  .rdata(rdata), .hit(hit), .err(err), .mask_vec(mask_vec), .sel(sel_q)
);

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
  localparam int CLK_T = 10;
  localparam int PINS = 24;
  localparam logic [31:0] BASE = 32'hFEC0_0000;
  localparam logic [7:0] A_SEL = 8'h00;
  localparam logic [7:0] A_WIN = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [31:0] base_addr = BASE;
  logic [31:0] bus_addr = BASE;
  logic rd = 1'b0;
  logic wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic hit, err;
  logic [PINS-1:0] mask_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_T/2) clk = ~clk;

  irq_route_regs uut (
    .clk(clk), .rst_n(rst_n), .en(en), .base_addr(base_addr), .bus_addr(bus_addr),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .hit(hit), .err(err),
    .mask_vec(mask_vec)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic bus_wr(input logic [7:0] off, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = {BASE[31:8], off}; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = {BASE[31:8], off}; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic win_rd(input logic [7:0] ix, input logic [31:0] exp, input string tag);
    bus_wr(A_SEL, {24'h0, ix});
    bus_rd(A_WIN, exp, tag);
  endtask

  task automatic win_wr(input logic [7:0] ix, input logic [31:0] d);
    bus_wr(A_SEL, {24'h0, ix});
    bus_wr(A_WIN, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    total++; bad++;
    $display("FAIL watchdog: got=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(32'(mask_vec), 32'h00FF_FFFF, "R1 mask_vec after reset");
    chk({31'h0, err}, 32'h0, "R10 err idle after reset");
    bus_rd(A_SEL, 32'h0, "R1 index reset");
    win_rd(8'h00, 32'h0, "R1 id reset");
    win_rd(8'h10, 32'h0001_0000, "R1 entry0 low");
    win_rd(8'h11, 32'h0, "R1 entry0 high");
    win_rd(8'h3E, 32'h0001_0000, "R1 entry23 low");
    chk({31'h0, err}, 32'h0, "R10 err after valid read");

    // R3 version
    win_rd(8'h01, 32'h0017_0001, "R3 version");
    win_wr(8'h01, 32'hFFFF_FFFF);
    chk({31'h0, err}, 32'h0, "R10 err after version write");
    bus_rd(A_WIN, 32'h0017_0001, "R3 version after write");

    // R4 id, R5 arb
    win_wr(8'h00, 32'hA5B6_C7D8);
    bus_rd(A_WIN, 32'h0500_0000, "R4 id load");
    win_rd(8'h02, 32'h0500_0000, "R5 arb reads id");
    bus_wr(A_WIN, 32'h0F00_0000);
    win_rd(8'h00, 32'h0500_0000, "R5 arb write keeps id");

    // R6 / R7 entry halves and mask mirror
    win_wr(8'h1A, 32'h0000_00FE);
    chk(32'(mask_vec), 32'h00FF_FFDF, "R7 mask clear pin5");
    win_wr(8'h1B, 32'hDEAD_BEEF);
    chk({31'h0, err}, 32'h0, "R10 err after entry write");
    win_rd(8'h1A, 32'h0000_00FE, "R6 low kept after high write");
    win_rd(8'h1B, 32'hDEAD_BEEF, "R6 high written");
    win_wr(8'h1A, 32'h0001_0031);
    chk(32'(mask_vec), 32'h00FF_FFFF, "R7 mask set pin5");
    win_rd(8'h1B, 32'hDEAD_BEEF, "R6 high kept after low write");
    win_wr(8'h3E, 32'h0);
    chk(32'(mask_vec), 32'h007F_FFFF, "R7 mask clear pin23");
    win_wr(8'h10, 32'h0);
    chk(32'(mask_vec), 32'h007F_FFFE, "R7 mask clear pin0");
    win_wr(8'h3F, 32'h1234_5678);
    win_rd(8'h3F, 32'h1234_5678, "R6 last valid index");

    // R9 invalid indices
    win_wr(8'h40, 32'hFFFF_FFFF);
    chk({31'h0, err}, 32'h1, "R9 err on write beyond table");
    chk(32'(mask_vec), 32'h007F_FFFE, "R9 dropped write keeps mask");
    @(posedge clk); #1;
    chk({31'h0, err}, 32'h0, "R10 err is one cycle");
    bus_rd(A_WIN, 32'h0, "R9 read beyond table");
    chk({31'h0, err}, 32'h1, "R9 err on read beyond table");
    win_rd(8'h05, 32'h0, "R9 read gap index");
    chk({31'h0, err}, 32'h1, "R9 err on gap index");
    win_rd(8'h3E, 32'h0, "R9 neighbour entry untouched");

    // R2 decode
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h20, 32'h0, "R2 other offset reads zero");
    bus_rd(8'h04, 32'h0, "R2 offset 4 reads zero");
    win_rd(8'h00, 32'h0500_0000, "R2 stray write no effect");
    @(posedge clk); #1;
    bus_addr = 32'h1234_5600; wdata = 32'h0000_001B; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
    bus_rd(A_SEL, 32'h0000_001B, "R2 index via upper-bit alias");
    @(posedge clk); #1;
    bus_addr = 32'hABCD_EF10; rd = 1'b1;
    exp_q.push_back(32'hDEAD_BEEF); tag_q.push_back("R2 window via upper-bit alias");
    @(posedge clk); #1;
    rd = 1'b0;

    // R8 hit window
    bus_addr = BASE - 1; #1;
    chk({31'h0, hit}, 32'h0, "R8 below base");
    bus_addr = BASE; #1;
    chk({31'h0, hit}, 32'h1, "R8 at base");
    bus_addr = BASE + 32'h100; #1;
    chk({31'h0, hit}, 32'h1, "R8 at top inclusive");
    bus_addr = BASE + 32'h101; #1;
    chk({31'h0, hit}, 32'h0, "R8 above top");
    en = 1'b0; bus_addr = BASE; #1;
    chk({31'h0, hit}, 32'h0, "R8 disabled");
    en = 1'b1;

    repeat (2) @(posedge clk);
    #1;
    chk(32'(exp_q.size()), 32'h0, "scoreboard drained");
    finish_run();
  end
endmodule